// File: doc/BRIEF.md
# Requester-to-Stream ID Translation Table

This block keeps, for one PCIe port, a small table that maps a 16-bit requester ID to a stream ID for an IOMMU. Each slot holds one 32-bit entry with a valid flag, a stream ID and a requester ID. The whole table can be zeroed in a single cycle, which is what port bring-up does before any mapping is made.

Software-side programming uses an insert-if-absent operation. The block walks the slots from index 0 upwards, one slot per cycle. It stops without writing at the first slot whose requester-ID field already equals the request. Valid slots are passed over. The first slot whose valid flag is clear is written. The block then reads that slot back and reports an error if the stored value differs, which is how a slot that is addressable but not built shows itself.

Transaction-side translation is a separate, purely combinational lookup. It returns a hit and the stored stream ID.

Top module: `rsid_map_table`

## Requirements
- R1: An entry is 32 bits wide. Bit 31 is the valid flag, bits 30:16 hold the 15-bit stream ID and bits 15:0 hold the requester ID. The full stream ID range, 0 to 0x7FFF, round-trips from insert to lookup.
- R2: Reset and a one-cycle `clear_all` pulse set every slot to zero. After either, every lookup misses.
- R3: Insert examines slots in ascending index. If a slot's bits 15:0 equal the requested ID, the insert reports success and writes nothing. This includes requester ID 0 against an empty, all-zero slot; such an insert leaves ID 0 unmapped.
- R4: During insert, a slot with its valid flag set is skipped. The first slot with the valid flag clear is written with valid set, the requested stream ID and the requested ID.
- R5: After the write, the slot is read back. If the value read differs from the value written, `ins_err` is 1 with `ins_done`.
- R6: If every addressable slot is valid and none matches, the insert ends with `ins_err` = 1.
- R7: Slots at or above `IMPL_SLOTS` and below `NUM_SLOTS` always read as zero and ignore writes. A mapping that lands in one of them is never visible to lookup.
- R8: A lookup reports `lk_hit` = 1 and the stream ID of a valid entry whose requester ID equals `lk_rid`, in the same cycle. On a miss, `lk_sid` is 0.
- R9: `ins_busy` is 1 from the cycle after an accepted `ins_start` until completion. `ins_done` is a one-cycle pulse, and `ins_err` is valid while it is high. An `ins_start` raised while busy is ignored, and the ID and stream ID captured at acceptance are the ones used.
- R10: `clear_all` takes priority over an insert in progress. It aborts the insert without a `ins_done` pulse and without any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Zero every slot; aborts an insert |
| ins_start | input | 1 | Request an insert-if-absent |
| ins_rid | input | 16 | Requester ID to insert |
| ins_sid | input | 15 | Stream ID to insert |
| ins_busy | output | 1 | Insert scan in progress |
| ins_done | output | 1 | One-cycle completion pulse |
| ins_err | output | 1 | Insert failed (valid with ins_done) |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | A valid entry matches lk_rid |
| lk_sid | output | 15 | Stream ID of the match, else 0 |

## Verification
The bench builds two copies of the table.

The first has 8 addressable slots of which only 6 are built. Filling it therefore pushes an insert onto an unbuilt slot after six entries, which reaches the read-back failure and the read-as-zero behaviour quickly.

The second has 4 slots, all built. Filling it exhausts the scan and reaches the no-free-slot error.

Both sizes keep every scan within a few cycles, so the busy-time start, the abort by clear and the requester-ID-zero quirk can each be driven at exact cycles.

// File: rtl/rsid_pkg.sv
package rsid_pkg;
  localparam int RID_W     = 16;
  localparam int ENTRY_W   = 32;
  localparam int VALID_BIT = 31;
  localparam int SID_LSB   = 16;
  localparam int SID_W     = VALID_BIT - SID_LSB;

  typedef enum logic [1:0] {
    INS_IDLE,
    INS_SCAN,
    INS_CHECK,
    INS_DONE
  } ins_state_e;

  function automatic logic [ENTRY_W-1:0] make_entry(logic [SID_W-1:0] sid,
                                                    logic [RID_W-1:0] rid);
    return {1'b1, sid, rid};
  endfunction

  function automatic logic entry_valid(logic [ENTRY_W-1:0] e);
    return e[VALID_BIT];
  endfunction

  function automatic logic [SID_W-1:0] entry_sid(logic [ENTRY_W-1:0] e);
    return e[VALID_BIT-1:SID_LSB];
  endfunction

  function automatic logic [RID_W-1:0] entry_rid(logic [ENTRY_W-1:0] e);
    return e[RID_W-1:0];
  endfunction
endpackage

// File: rtl/rsid_store.sv
module rsid_store
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 64,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [ENTRY_W-1:0]                 wr_data,
  input  logic [IDX_W-1:0]                   rd_idx,
  output logic [ENTRY_W-1:0]                 rd_data,
  output logic [NUM_SLOTS-1:0][ENTRY_W-1:0]  slots
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < IMPL_SLOTS) begin : g_built
      logic [ENTRY_W-1:0] val_q;
      logic               hit_w;
      assign hit_w = wr_en && (wr_idx == IDX_W'(s));
      always_ff @(posedge clk) begin
        if (!rst_n || clr) val_q <= '0;
        else if (hit_w)    val_q <= wr_data;
      end
      assign slots[s] = val_q;
    end else begin : g_absent
      assign slots[s] = '0;
    end
  end

  assign rd_data = slots[rd_idx];

  // R7: slots that are not built always read as zero
  assert_unbuilt_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= IMPL_SLOTS) |-> (rd_data == '0));

  // R4: a write never lands on a slot that already holds a valid entry
  assert_write_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !entry_valid(slots[wr_idx]));
endmodule

// File: rtl/rsid_lookup.sv
module rsid_lookup
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS = 64
) (
  input  logic [NUM_SLOTS-1:0][ENTRY_W-1:0] slots,
  input  logic [RID_W-1:0]                  lk_rid,
  output logic                              lk_hit,
  output logic [SID_W-1:0]                  lk_sid
);
  // descending walk so the lowest matching index wins
  always_comb begin
    lk_hit = 1'b0;
    lk_sid = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (entry_valid(slots[s]) && entry_rid(slots[s]) == lk_rid) begin
        lk_hit = 1'b1;
        lk_sid = entry_sid(slots[s]);
      end
    end
  end
endmodule

// File: rtl/rsid_insert_ctl.sv
module rsid_insert_ctl
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 64,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start,
  input  logic [RID_W-1:0]   rid,
  input  logic [SID_W-1:0]   sid,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [ENTRY_W-1:0] rd_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRY_W-1:0] wr_data,
  output logic               busy,
  output logic               done,
  output logic               err
);
  ins_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [RID_W-1:0]   rid_q;
  logic [SID_W-1:0]   sid_q;
  logic               err_q;

  // named scan events
  logic scan_match, scan_skip, scan_last, readback_bad;
  assign scan_match   = (state_q == INS_SCAN) && (entry_rid(rd_data) == rid_q);
  assign scan_skip    = (state_q == INS_SCAN) && !scan_match && entry_valid(rd_data);
  assign scan_last    = (idx_q == IDX_W'(NUM_SLOTS - 1));
  assign readback_bad = (rd_data != make_entry(sid_q, rid_q));

  assign rd_idx  = idx_q;
  assign wr_idx  = idx_q;
  assign wr_data = make_entry(sid_q, rid_q);
  assign wr_en   = (state_q == INS_SCAN) && !scan_match && !scan_skip && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= INS_IDLE;
      idx_q   <= '0;
      rid_q   <= '0;
      sid_q   <= '0;
      err_q   <= 1'b0;
    end else if (clr) begin
      state_q <= INS_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        INS_IDLE: if (start) begin
          idx_q   <= '0;
          rid_q   <= rid;
          sid_q   <= sid;
          state_q <= INS_SCAN;
        end
        INS_SCAN: begin
          if (scan_match) begin
            err_q   <= 1'b0;
            state_q <= INS_DONE;
          end else if (scan_skip) begin
            if (scan_last) begin
              err_q   <= 1'b1;
              state_q <= INS_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            state_q <= INS_CHECK;
          end
        end
        INS_CHECK: begin
          err_q   <= readback_bad;
          state_q <= INS_DONE;
        end
        default: state_q <= INS_IDLE;
      endcase
    end
  end

  assign busy = (state_q == INS_SCAN) || (state_q == INS_CHECK);
  assign done = (state_q == INS_DONE);
  assign err  = err_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == INS_IDLE && start && !clr) |=> busy);

  assert_clear_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !done));

  // R5: a write into an unbuilt slot must report failure
  assert_unbuilt_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == INS_CHECK && int'(idx_q) >= IMPL_SLOTS && !clr) |=> (done && err));
endmodule

// File: rtl/rsid_map_table.sv
module rsid_map_table
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_all,
  input  logic                       ins_start,
  input  logic [15:0]                ins_rid,
  input  logic [14:0]                ins_sid,
  output logic                       ins_busy,
  output logic                       ins_done,
  output logic                       ins_err,
  input  logic [15:0]                lk_rid,
  output logic                       lk_hit,
  output logic [14:0]                lk_sid
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0][ENTRY_W-1:0] slots_w;
  logic [IDX_W-1:0]                  rd_idx_w, wr_idx_w;
  logic [ENTRY_W-1:0]                rd_data_w, wr_data_w;
  logic                              wr_en_w;

  rsid_store #(.NUM_SLOTS(NUM_SLOTS), .IMPL_SLOTS(IMPL_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clear_all),
    .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .rd_idx(rd_idx_w), .rd_data(rd_data_w), .slots(slots_w)
  );

  rsid_insert_ctl #(.NUM_SLOTS(NUM_SLOTS), .IMPL_SLOTS(IMPL_SLOTS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .clr(clear_all), .start(ins_start),
    .rid(ins_rid), .sid(ins_sid),
    .rd_idx(rd_idx_w), .rd_data(rd_data_w),
    .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .busy(ins_busy), .done(ins_done), .err(ins_err)
  );

  rsid_lookup #(.NUM_SLOTS(NUM_SLOTS)) u_lookup (
    .slots(slots_w), .lk_rid(lk_rid), .lk_hit(lk_hit), .lk_sid(lk_sid)
  );

  assert_miss_sid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == '0));

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> !lk_hit);

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_busy && ins_done));
endmodule

// File: tb/rsid_map_table_tb.sv
module rsid_map_table_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_all = 1'b0;
  logic        start_a = 1'b0, start_b = 1'b0;
  logic [15:0] ins_rid = '0;
  logic [14:0] ins_sid = '0;
  logic [15:0] lk_rid = '0;
  logic        busy_a, done_a, err_a, hit_a;
  logic [14:0] sid_a;
  logic        busy_b, done_b, err_b, hit_b;
  logic [14:0] sid_b;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsid_map_table #(.NUM_SLOTS(8), .IMPL_SLOTS(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .ins_start(start_a),
    .ins_rid(ins_rid), .ins_sid(ins_sid), .ins_busy(busy_a), .ins_done(done_a),
    .ins_err(err_a), .lk_rid(lk_rid), .lk_hit(hit_a), .lk_sid(sid_a)
  );

  rsid_map_table #(.NUM_SLOTS(4), .IMPL_SLOTS(4)) u_dut_full (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .ins_start(start_b),
    .ins_rid(ins_rid), .ins_sid(ins_sid), .ins_busy(busy_b), .ins_done(done_b),
    .ins_err(err_b), .lk_rid(lk_rid), .lk_hit(hit_b), .lk_sid(sid_b)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  // wait for the done pulse of one instance; returns its error flag
  task automatic wait_done(input bit which, input string req, output bit e);
    bit seen = 0;
    e = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if ((which ? done_b : done_a) === 1'b1) begin
        seen = 1;
        e = which ? err_b : err_a;
      end
    end
    check({req, " done seen"}, int'(seen), 1);
  endtask

  task automatic insert(input bit which, input logic [15:0] rid,
                        input logic [14:0] sid, input string req, output bit e);
    @(negedge clk);
    ins_rid = rid; ins_sid = sid;
    if (which) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    check({req, " busy"}, int'(which ? busy_b : busy_a), 1);
    wait_done(which, req, e);
  endtask

  task automatic look(input bit which, input logic [15:0] rid, input string req,
                      input bit exp_hit, input int exp_sid);
    @(negedge clk);
    lk_rid = rid;
    #1;
    check({req, " hit"}, int'(which ? hit_b : hit_a), int'(exp_hit));
    check({req, " sid"}, int'(which ? sid_b : sid_a), exp_sid);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
  endtask

  task automatic test_reset();
    check("R2 reset busy", int'(busy_a), 0);
    check("R9 reset done", int'(done_a), 0);
    look(0, 16'h1234, "R2 reset lookup", 0, 0);
    look(0, 16'h0000, "R2 reset lookup rid0", 0, 0);
  endtask

  task automatic test_rid_zero();
    bit e;
    insert(0, 16'h0000, 15'h0003, "R3 rid0", e);
    check("R3 rid0 err", int'(e), 0);
    look(0, 16'h0000, "R3 rid0 unmapped", 0, 0);
  endtask

  task automatic test_basic_and_dup();
    bit e;
    insert(0, 16'h0101, 15'h0005, "R4 first", e);
    check("R4 first err", int'(e), 0);
    look(0, 16'h0101, "R8 first lookup", 1, 5);
    insert(0, 16'h0101, 15'h0009, "R3 dup", e);
    check("R3 dup err", int'(e), 0);
    look(0, 16'h0101, "R3 dup keeps sid", 1, 5);
  endtask

  task automatic test_fill_unbuilt();
    bit e;
    insert(0, 16'h0202, 15'h7FFF, "R1 max sid", e);
    check("R1 max sid err", int'(e), 0);
    look(0, 16'h0202, "R1 max sid lookup", 1, 32'h7FFF);
    for (int k = 3; k <= 6; k++) begin
      insert(0, 16'(k * 16'h0101), 15'(k + 16), "R4 fill", e);
      check("R4 fill err", int'(e), 0);
    end
    look(0, 16'h0404, "R8 middle lookup", 1, 20);
    look(0, 16'h0203, "R8 near miss", 0, 0);
    insert(0, 16'h0707, 15'h0011, "R5 unbuilt", e);
    check("R5 unbuilt err", int'(e), 1);
    look(0, 16'h0707, "R7 unbuilt ignored", 0, 0);
  endtask

  task automatic test_clear();
    pulse_clear();
    look(0, 16'h0101, "R2 clear lookup", 0, 0);
    look(0, 16'h0606, "R2 clear lookup last", 0, 0);
  endtask

  task automatic test_start_while_busy();
    bit e;
    @(negedge clk);
    ins_rid = 16'h0A0A; ins_sid = 15'h0021; start_a = 1'b1;
    @(negedge clk);
    ins_rid = 16'h0B0B; ins_sid = 15'h0022;
    @(negedge clk);
    start_a = 1'b0;
    wait_done(0, "R9 busy start", e);
    check("R9 busy start err", int'(e), 0);
    look(0, 16'h0A0A, "R9 first captured", 1, 32'h21);
    look(0, 16'h0B0B, "R9 second ignored", 0, 0);
  endtask

  task automatic test_clear_abort();
    bit seen = 0;
    @(negedge clk);
    ins_rid = 16'h0C0C; ins_sid = 15'h0031; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    check("R10 abort busy", int'(busy_a), 0);
    for (int i = 0; i < 12; i++) begin
      if (done_a === 1'b1) seen = 1;
      @(negedge clk);
    end
    check("R10 abort no done", int'(seen), 0);
    look(0, 16'h0C0C, "R10 abort no write", 0, 0);
  endtask

  task automatic test_table_full();
    bit e;
    for (int k = 1; k <= 4; k++) begin
      insert(1, 16'(16'h1000 + k), 15'(k), "R6 fill", e);
      check("R6 fill err", int'(e), 0);
    end
    insert(1, 16'h2000, 15'h0044, "R6 full", e);
    check("R6 full err", int'(e), 1);
    look(1, 16'h1004, "R8 full last slot", 1, 4);
    look(1, 16'h2000, "R6 full not mapped", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rid_zero();
    test_basic_and_dup();
    test_fill_unbuilt();
    test_clear();
    test_start_while_busy();
    test_clear_abort();
    test_table_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule